// File: doc/BRIEF.md
# Registered Bidirectional Transceiver with Ready Flags

This block sits between two 8-bit data ports, called A and B. It holds one word for each direction, and each word waits in its own holding register until the other side reads it. A writer loads a register with a strobe, but only while that direction's active-low load enable is low. The load raises a ready flag for the reader. The reader turns on the output by pulling its active-low read enable low. When it releases that enable, the flag drops, which tells the writer the word has been taken.

In the A-to-B direction, a parity bit is driven next to the B data. That bit makes the total count of ones odd. In the B-to-A direction, an incoming parity bit is captured together with the B word. While the A side is being read, an active-low error output reports whether the stored word and its bit fail the odd-count rule.

The block runs on a single system clock. Both load strobes and both read enables pass through a synchroniser with a parameterised depth, and their rising edges are detected after it. Each port that would be tri-stated is modelled as a data bus plus an enable output. A released bus reads as all zeros.

Top module: `flagged_xfer_xcvr`

## Requirements
- R1: A qualified load copies the port data into its holding register. A load is qualified when the strobe rises while the active-low load enable is low. With the default synchroniser depth of 2, the register takes the new value on the third system clock edge after the strobe rises.
- R2: A strobe rising edge while the load enable is high changes neither the register nor the flag.
- R3: A qualified load sets that direction's ready flag to 1.
- R4: A rising edge on a direction's active-low read enable clears that direction's flag. The flag is cleared on the third clock edge after the rise.
- R5: While the A-to-B read enable is low, `b_oe` and `par_oe` are 1 and `b_out` carries the register. While it is high, both enables are 0 and `b_out` and `par_out` are 0.
- R6: `par_out` is 1 when the A-to-B register holds an even number of ones (zero counts as even). It is 0 when the count is odd.
- R7: A qualified B-to-A load captures `b_in` and `par_in` on the same clock edge.
- R8: While the B-to-A read enable is low, `err_n` is 1 when the stored word plus the stored parity bit hold an odd number of ones. It is 0 when they hold an even number. While the read enable is high, `err_n` is 1.
- R9: While the B-to-A read enable is low, `a_oe` is 1 and `a_out` carries the stored word. Otherwise `a_oe` is 0 and `a_out` is 0.
- R10: A synchronous active-high reset clears both registers, the stored parity bit and both flags.
- R11: When a qualified load and a read-enable rising edge land in the same clock cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | A port data toward B |
| ab_strobe | input | 1 | Load strobe, A-to-B register |
| ab_load_n | input | 1 | Active-low load enable, A-to-B |
| ab_read_n | input | 1 | Active-low read enable, B side |
| b_out | output | 8 | B port driven data |
| b_oe | output | 1 | B port drive enable |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Parity bit drive enable |
| ab_flag | output | 1 | A-to-B word ready |
| b_in | input | 8 | B port data toward A |
| par_in | input | 1 | Incoming parity bit |
| ba_strobe | input | 1 | Load strobe, B-to-A register |
| ba_load_n | input | 1 | Active-low load enable, B-to-A |
| ba_read_n | input | 1 | Active-low read enable, A side |
| a_out | output | 8 | A port driven data |
| a_oe | output | 1 | A port drive enable |
| err_n | output | 1 | Active-low parity check result |
| ba_flag | output | 1 | B-to-A word ready |

## Verification
The bench sweeps all 256 words through the A-to-B path and checks the parity bit against a population count. A design with the wrong sense would give an inverted `par_out` for the all-zeros word. It sweeps all 256 words with both parity-bit values through the B-to-A path. A design that sampled the parity bit on a different edge from the data would report false errors. It strobes with the load enable high to catch a register or flag that ignores the enable. It lines up a load with a read release to catch a design in which the clear overrides the set. It also checks the released buses and the idle `err_n` level.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XCVR_DATA_W   = 8;
    localparam int XCVR_SYNC_DEP = 2;
    localparam int XCVR_MAX_W    = 64;

    typedef enum logic [1:0] {
        FLAG_KEEP  = 2'd0,
        FLAG_RAISE = 2'd1,
        FLAG_DROP  = 2'd2
    } flag_act_e;

    // 1 when the vector carries an odd number of ones
    function automatic logic odd_ones(input logic [XCVR_MAX_W-1:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/xcvr_edge_sync.sv
module xcvr_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else if (g == 0) chain[g] <= d;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/xcvr_hold_path.sv
module xcvr_hold_path
    import xcvr_pkg::*;
#(
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          load_n,
    input  logic          read_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] data_q,
    output logic          flag
);
    logic st_lvl, st_rise, ld_lvl, ld_rise, rd_lvl, rd_rise;
    logic      do_load;
    flag_act_e act;

    xcvr_edge_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_st (
        .clk(clk), .rst(rst), .d(strobe), .lvl(st_lvl), .rise(st_rise));
    xcvr_edge_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_ld (
        .clk(clk), .rst(rst), .d(load_n), .lvl(ld_lvl), .rise(ld_rise));
    xcvr_edge_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_rd (
        .clk(clk), .rst(rst), .d(read_n), .lvl(rd_lvl), .rise(rd_rise));

    assign do_load = st_rise & ~ld_lvl;

    always_comb begin
        if (do_load)      act = FLAG_RAISE;
        else if (rd_rise) act = FLAG_DROP;
        else              act = FLAG_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            flag   <= 1'b0;
        end else begin
            if (do_load) data_q <= din;
            case (act)
                FLAG_RAISE: flag <= 1'b1;
                FLAG_DROP:  flag <= 1'b0;
                default:    flag <= flag;
            endcase
        end
    end

    // R1: qualified load captures the input word
    p_load_cap_r1: assert property (@(posedge clk) disable iff (rst)
        (st_rise && !ld_lvl) |=> data_q == $past(din));
    // R2: no qualified load, register holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(st_rise && !ld_lvl) |=> $stable(data_q));
    // R3 and R11: load always leaves the flag set
    p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
        (st_rise && !ld_lvl) |=> flag);
    // R4: read release without a load clears the flag
    p_flag_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_rise && !(st_rise && !ld_lvl)) |=> !flag);
    // R2: flag stays put with no events
    p_flag_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (!rd_rise && !(st_rise && !ld_lvl)) |=> $stable(flag));

    logic unused_ok;
    assign unused_ok = ld_rise | rd_lvl | st_lvl;

endmodule

// File: rtl/flagged_xfer_xcvr.sv
module flagged_xfer_xcvr
    import xcvr_pkg::*;
#(
    parameter int W      = XCVR_DATA_W,
    parameter int STAGES = XCVR_SYNC_DEP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic         ab_strobe,
    input  logic         ab_load_n,
    input  logic         ab_read_n,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         par_out,
    output logic         par_oe,
    output logic         ab_flag,
    input  logic [W-1:0] b_in,
    input  logic         par_in,
    input  logic         ba_strobe,
    input  logic         ba_load_n,
    input  logic         ba_read_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic         err_n,
    output logic         ba_flag
);
    localparam int BA_W = W + 1;

    logic [W-1:0]    ab_q;
    logic [BA_W-1:0] ba_q;
    logic            ab_drive, ba_drive;

    xcvr_hold_path #(.DW(W), .STAGES(STAGES)) u_ab (
        .clk(clk), .rst(rst), .strobe(ab_strobe), .load_n(ab_load_n),
        .read_n(ab_read_n), .din(a_in), .data_q(ab_q), .flag(ab_flag));

    xcvr_hold_path #(.DW(BA_W), .STAGES(STAGES)) u_ba (
        .clk(clk), .rst(rst), .strobe(ba_strobe), .load_n(ba_load_n),
        .read_n(ba_read_n), .din({par_in, b_in}), .data_q(ba_q), .flag(ba_flag));

    assign ab_drive = ~ab_read_n;
    assign ba_drive = ~ba_read_n;

    assign b_oe    = ab_drive;
    assign par_oe  = ab_drive;
    assign b_out   = ab_drive ? ab_q : '0;
    assign par_out = ab_drive ? ~odd_ones(XCVR_MAX_W'(ab_q)) : 1'b0;

    assign a_oe    = ba_drive;
    assign a_out   = ba_drive ? ba_q[W-1:0] : '0;
    assign err_n   = ba_drive ? odd_ones(XCVR_MAX_W'(ba_q)) : 1'b1;

    // R5: released B side drives nothing
    p_b_release_r5: assert property (@(posedge clk) disable iff (rst)
        ab_read_n |-> (b_out == '0 && !par_out && !par_oe && !b_oe));
    // R6: driven B word plus parity bit always odd
    p_par_odd_r6: assert property (@(posedge clk) disable iff (rst)
        par_oe |-> (^{par_out, b_out}) == 1'b1);
    // R8: idle error output is high
    p_err_idle_r8: assert property (@(posedge clk) disable iff (rst)
        ba_read_n |-> err_n);
    // R9: released A side drives nothing
    p_a_release_r9: assert property (@(posedge clk) disable iff (rst)
        ba_read_n |-> (a_out == '0 && !a_oe));

endmodule

// File: tb/flagged_xfer_xcvr_bench.sv
module flagged_xfer_xcvr_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_in = '0, b_in = '0;
    logic       ab_strobe = 0, ab_load_n = 0, ab_read_n = 1;
    logic       par_in = 0, ba_strobe = 0, ba_load_n = 0, ba_read_n = 1;
    logic [7:0] b_out, a_out;
    logic       b_oe, par_out, par_oe, ab_flag, a_oe, err_n, ba_flag;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    flagged_xfer_xcvr u_flagged_xfer_xcvr (
        .clk(clk), .rst(rst), .a_in(a_in), .ab_strobe(ab_strobe),
        .ab_load_n(ab_load_n), .ab_read_n(ab_read_n), .b_out(b_out),
        .b_oe(b_oe), .par_out(par_out), .par_oe(par_oe), .ab_flag(ab_flag),
        .b_in(b_in), .par_in(par_in), .ba_strobe(ba_strobe),
        .ba_load_n(ba_load_n), .ba_read_n(ba_read_n), .a_out(a_out),
        .a_oe(a_oe), .err_n(err_n), .ba_flag(ba_flag));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ab_push(input logic [7:0] d);
        a_in = d; ab_strobe = 1; waitn(4); ab_strobe = 0; waitn(2);
    endtask

    task automatic ba_push(input logic [7:0] d, input logic p);
        b_in = d; par_in = p; ba_strobe = 1; waitn(4); ba_strobe = 0; waitn(2);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        waitn(3); rst = 0; waitn(1);
        // R10: reset state
        chk("R10 ab_flag", ab_flag, 0);
        chk("R10 ba_flag", ba_flag, 0);
        // R5 R9 R8: released outputs
        chk("R5 b_oe", b_oe, 0);  chk("R5 par_oe", par_oe, 0);
        chk("R5 b_out", b_out, 0); chk("R5 par_out", par_out, 0);
        chk("R9 a_oe", a_oe, 0);  chk("R9 a_out", a_out, 0);
        chk("R8 err_n idle", err_n, 1);

        // R1 latency: third edge after strobe rise
        a_in = 8'h5A; ab_strobe = 1;
        @(posedge clk); @(posedge clk); #1;
        chk("R1 not yet flagged", ab_flag, 0);
        @(posedge clk); #1;
        chk("R1 R3 flag on third edge", ab_flag, 1);
        waitn(3); ab_strobe = 0; waitn(2);

        // R1 R3 R4 R5 R6: A-to-B sweep
        for (int v = 0; v < 256; v++) begin
            ab_push(v[7:0]);
            chk("R3 ab_flag set", ab_flag, 1);
            ab_read_n = 0; waitn(1);
            chk("R1 b_out", b_out, v[7:0]);
            chk("R5 b_oe", {b_oe, par_oe}, 2'b11);
            chk("R6 parity", par_out, ($countones(v[7:0]) % 2 == 0) ? 1 : 0);
            ab_read_n = 1; waitn(1);
            chk("R4 flag held until sync", ab_flag, 1);
            waitn(3);
            chk("R4 ab_flag clear", ab_flag, 0);
        end

        // R2: strobe with load enable high leaves word and flag
        ab_load_n = 1; ab_push(8'h3C);
        chk("R2 ab_flag unchanged", ab_flag, 0);
        ab_read_n = 0; waitn(1);
        chk("R2 b_out kept", b_out, 8'hFF);
        ab_read_n = 1; waitn(4); ab_load_n = 0;

        // R7 R8 R9 R3 R4: B-to-A sweep, both parity values
        for (int v = 0; v < 512; v++) begin
            ba_push(v[7:0], v[8]);
            chk("R3 ba_flag set", ba_flag, 1);
            chk("R8 err_n idle", err_n, 1);
            ba_read_n = 0; waitn(1);
            chk("R9 a_out", a_out, v[7:0]);
            chk("R9 a_oe", a_oe, 1);
            chk("R7 R8 err_n", err_n, (($countones(v[7:0]) + v[8]) % 2 == 1) ? 1 : 0);
            ba_read_n = 1; waitn(4);
            chk("R4 ba_flag clear", ba_flag, 0);
        end

        // R2 on B-to-A: stored parity bit must survive a disabled strobe
        ba_push(8'h01, 1'b0);
        ba_read_n = 0; waitn(1); ba_read_n = 1; waitn(4);
        ba_load_n = 1; ba_push(8'h00, 1'b0);
        ba_read_n = 0; waitn(1);
        chk("R2 a_out kept", a_out, 8'h01);
        chk("R2 err_n kept", err_n, 1);
        ba_read_n = 1; waitn(4); ba_load_n = 0;
        chk("R2 ba_flag unchanged", ba_flag, 0);

        // R11: load and read release in the same cycle, both directions
        ab_read_n = 0; ba_read_n = 0; waitn(1);
        a_in = 8'h81; b_in = 8'h7E; par_in = 1;
        ab_strobe = 1; ab_read_n = 1; ba_strobe = 1; ba_read_n = 1;
        waitn(5); ab_strobe = 0; ba_strobe = 0; waitn(2);
        chk("R11 ab_flag set wins", ab_flag, 1);
        chk("R11 ba_flag set wins", ba_flag, 1);

        // R10: reset clears registers and flags
        @(negedge clk); rst = 1; waitn(2); rst = 0; waitn(1);
        chk("R10 ab_flag", ab_flag, 0);
        chk("R10 ba_flag", ba_flag, 0);
        ab_read_n = 0; ba_read_n = 0; waitn(1);
        chk("R10 ab word", b_out, 0);
        chk("R10 ba word", a_out, 0);
        chk("R10 stored parity", err_n, 0);
        ab_read_n = 1; ba_read_n = 1; waitn(4);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule